// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a byte-wide nonvolatile memory. It decides what a host sees when it reads while an internal program cycle is still running, so that software can poll until the write has finished. When no write is in progress it returns the stored array data unchanged. While a write is in progress it replaces two bits of the read data with status indications, and it returns true data again once programming ends.

Two independent polling methods share the data bus. The most significant bit of a read aimed at the most recently written address returns the inverse of what was written to that bit. The next bit down changes state on every new read access, so two reads in a row that return different values in that bit mean the device is still busy. A new read access is the moment both the chip-select and read-enable inputs become active, whether the host got there by cycling chip-select, read-enable or both. The bus drivers themselves are outside the block. It produces a drive-enable flag instead.

Top module: `wr_status_reporter`

## Requirements
- R1: `drive_en_o` is 1 exactly when both `ce_n_i` and `oe_n_i` are 0, and it follows them in the same cycle.
- R2: While `drive_en_o` is 0, `rd_data_o` is all zeros.
- R3: While `busy_i` is 0 and the read is enabled, `rd_data_o` equals `array_data_i` on all 8 bits.
- R4: While `busy_i` is 1 and `rd_addr_i` equals `last_addr_i`, bit 7 of `rd_data_o` is the inverse of `last_wr_msb_i`. This holds from the first read in the write cycle, with no delay.
- R5: While `busy_i` is 1 and `rd_addr_i` differs from `last_addr_i`, bit 7 of `rd_data_o` equals bit 7 of `array_data_i`.
- R6: While `busy_i` is 1, every new read access (a clock in which the read is enabled after a clock in which it was not) inverts bit 6 of `rd_data_o`. The new value shows one clock edge after the access begins. The absolute value of bit 6 is not defined.
- R7: Bit 6 advances once per read access and not once per clock. Holding a read enabled over many clocks keeps bit 6 constant.
- R8: Returning `ce_n_i` alone high and then low, with `oe_n_i` held low, counts as a new read access for R6. So does doing the same with `oe_n_i` alone, or with both.
- R9: Bits 5 to 0 of `rd_data_o` during a busy read carry the matching bits of `array_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy_i | input | 1 | Internal program cycle in progress |
| last_addr_i | input | 15 | Address of the last byte loaded for programming |
| last_wr_msb_i | input | 1 | Bit 7 of the last byte loaded for programming |
| rd_addr_i | input | 15 | Address of the current read |
| array_data_i | input | 8 | Data read from the storage array at `rd_addr_i` |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Read enable, active low |
| rd_data_o | output | 8 | Data returned to the host |
| drive_en_o | output | 1 | Data bus should be driven |

## Verification
On every cycle, the embedded assertions check the enable gating, the zero output when idle, the pass-through when not busy, and the inverted bit 7 on a busy read of the last written address. They also check that the toggle state flips on each detected access and holds otherwise. What they cannot show is that bit 6 alternates across a series of host reads, stays put across a long read, and responds to chip-select cycling and to read-enable cycling alike. The directed scenarios demonstrate those by comparing sampled read values.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 15;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_PASS = 2'd1,
    SEL_POLL = 2'd2
  } out_sel_e;
endpackage

// File: rtl/wsr_strobe_det.sv
module wsr_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic oe_n_i,
  output logic rd_active_o,
  output logic strobe_o
);
  logic rd_q;
  logic rd_d;

  assign rd_active_o = ~ce_n_i & ~oe_n_i;
  assign strobe_o    = rd_active_o & ~rd_q;

  always_comb begin
    rd_d = rd_active_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end

  // R6
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> rd_q);
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic strobe_i,
  output logic tog_o
);
  logic tog_q;
  logic tog_d;
  logic tog_en;

  assign tog_en = busy_i & strobe_i;

  always_comb begin
    tog_d = tog_q;
    if (tog_en) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  assign tog_o = tog_q;

  // R6
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && strobe_i) |=> (tog_q != $past(tog_q)));
  // R7
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_i && strobe_i) |=> $stable(tog_q));
endmodule

// File: rtl/wsr_out_mux.sv
module wsr_out_mux
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  out_sel_e          sel_i,
  input  logic              addr_hit_i,
  input  logic              last_msb_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  always_comb begin
    rd_data_o = '0;
    case (sel_i)
      SEL_PASS: rd_data_o = array_data_i;
      SEL_POLL: begin
        rd_data_o           = array_data_i;
        rd_data_o[POLL_BIT] = addr_hit_i ? ~last_msb_i : array_data_i[POLL_BIT];
        rd_data_o[TOG_BIT]  = tog_i;
      end
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic              last_wr_msb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              drive_en_o
);
  localparam int unsigned POLL_BIT = DATA_W - 1;

  logic     rst_meta;
  logic     rst_sync;
  logic     rd_active;
  logic     strobe;
  logic     tog;
  logic     addr_hit;
  out_sel_e sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  wsr_strobe_det u_strobe (
    .clk        (clk),
    .rst_n      (rst_sync),
    .ce_n_i     (ce_n_i),
    .oe_n_i     (oe_n_i),
    .rd_active_o(rd_active),
    .strobe_o   (strobe)
  );

  wsr_toggle u_toggle (
    .clk     (clk),
    .rst_n   (rst_sync),
    .busy_i  (busy_i),
    .strobe_i(strobe),
    .tog_o   (tog)
  );

  assign addr_hit = (rd_addr_i == last_addr_i);

  always_comb begin
    if (!rd_active)  sel = SEL_IDLE;
    else if (busy_i) sel = SEL_POLL;
    else             sel = SEL_PASS;
  end

  wsr_out_mux #(.DATA_W(DATA_W)) u_mux (
    .sel_i       (sel),
    .addr_hit_i  (addr_hit),
    .last_msb_i  (last_wr_msb_i),
    .tog_i       (tog),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o)
  );

  assign drive_en_o = rd_active;

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !drive_en_o |-> (rd_data_o == '0));
  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (drive_en_o && !busy_i) |-> (rd_data_o == array_data_i));
  // R4
  poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (drive_en_o && busy_i && (rd_addr_i == last_addr_i))
      |-> (rd_data_o[POLL_BIT] != last_wr_msb_i));
  // R1
  enable_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    drive_en_o |-> (!ce_n_i && !oe_n_i));
endmodule

// File: tb/wr_status_reporter_test.sv
module wr_status_reporter_test;
  localparam int AW = 15;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          busy;
  logic [AW-1:0] last_addr;
  logic          last_msb;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] arr;
  logic          ce_n;
  logic          oe_n;
  logic [DW-1:0] rd_data;
  logic          drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wr_status_reporter uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy),
    .last_addr_i  (last_addr),
    .last_wr_msb_i(last_msb),
    .rd_addr_i    (rd_addr),
    .array_data_i (arr),
    .ce_n_i       (ce_n),
    .oe_n_i       (oe_n),
    .rd_data_o    (rd_data),
    .drive_en_o   (drv)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at negedge, settle combinational paths
  task automatic settle();
    #1;
  endtask

  // one new read access: idle for a cycle, then enable; sample after the edge
  task automatic new_read(input bit via_ce, input bit via_oe, output logic b6);
    @(negedge clk);
    if (via_ce) ce_n = 1'b1;
    if (via_oe) oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    oe_n = 1'b0;
    @(posedge clk);
    #1;
    b6 = rd_data[6];
  endtask

  task automatic t_reset();
    rst_n = 1'b0; busy = 1'b0; last_addr = '0; last_msb = 1'b0;
    rd_addr = '0; arr = 8'h00; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    settle();
    check("R1 reset drive", {7'd0, drv}, 8'h00);
    check("R2 reset data", rd_data, 8'h00);
  endtask

  task automatic t_gating();
    @(negedge clk); arr = 8'hA5; ce_n = 1'b0; oe_n = 1'b1; settle();
    check("R1 ce only", {7'd0, drv}, 8'h00);
    check("R2 ce only", rd_data, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; settle();
    check("R1 oe only", {7'd0, drv}, 8'h00);
    @(negedge clk); ce_n = 1'b0; settle();
    check("R1 both low", {7'd0, drv}, 8'h01);
  endtask

  task automatic t_pass();
    logic [DW-1:0] pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
    busy = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); arr = pats[i]; rd_addr = AW'(i * 77); settle();
      check("R3 pass", rd_data, pats[i]);
    end
  endtask

  task automatic t_poll();
    @(negedge clk);
    last_addr = 15'h1234; last_msb = 1'b1; rd_addr = 15'h1234;
    arr = 8'hFF; busy = 1'b1; settle();
    check("R4 first read msb=1", {7'd0, rd_data[7]}, 8'h00);
    check("R9 low bits", {2'b00, rd_data[5:0]}, 8'h3F);
    @(negedge clk); last_msb = 1'b0; arr = 8'h00; settle();
    check("R4 msb=0", {7'd0, rd_data[7]}, 8'h01);
    @(negedge clk); rd_addr = 15'h1235; arr = 8'h80; settle();
    check("R5 other addr", {7'd0, rd_data[7]}, 8'h01);
    @(negedge clk); arr = 8'h2A; settle();
    check("R5 other addr low", {7'd0, rd_data[7]}, 8'h00);
    check("R9 low bits 2", {2'b00, rd_data[5:0]}, 8'h2A);
  endtask

  task automatic t_toggle();
    logic a, b, c, d, e;
    busy = 1'b1; rd_addr = 15'h1234;
    new_read(1'b0, 1'b1, a);
    new_read(1'b0, 1'b1, b);
    check("R6 oe reads differ", {7'd0, a ^ b}, 8'h01);
    repeat (6) @(posedge clk);
    #1;
    check("R7 held read stable", {7'd0, rd_data[6]}, {7'd0, b});
    new_read(1'b1, 1'b0, c);
    check("R8 ce cycle flips", {7'd0, b ^ c}, 8'h01);
    new_read(1'b1, 1'b1, d);
    check("R8 both cycle flips", {7'd0, c ^ d}, 8'h01);
    new_read(1'b0, 1'b1, e);
    check("R6 third flip", {7'd0, d ^ e}, 8'h01);
  endtask

  task automatic t_done();
    @(negedge clk); busy = 1'b0; arr = 8'h3C; rd_addr = 15'h1234; settle();
    check("R3 after completion", rd_data, 8'h3C);
    @(negedge clk); ce_n = 1'b1; settle();
    check("R2 deselect", rd_data, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_gating();
    t_pass();
    t_poll();
    t_toggle();
    t_done();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule